// File: doc/BRIEF.md
# Single-Word Four-Phase Handshake Buffer

This block carries one data word from a producing agent to a consuming agent. Each side runs its own return-to-zero request/acknowledge exchange. On the source side the producer drives a word and raises a request. The buffer takes the word only when its single slot is empty, and it answers with an acknowledge that it keeps high until the producer withdraws the request. On the sink side the buffer offers the stored word by raising its own request. The consumer answers with an acknowledge, the buffer withdraws the request, and the consumer then lowers its acknowledge.

Because the slot holds exactly one word, stores and deliveries strictly alternate. A producer that arrives while the slot is occupied simply waits: its request goes unanswered until the previous word has been taken. A parameter selects whether the outgoing data bus shows zero while no offer is open, or always shows the stored word. The reset is synchronous and active high.

Top module: `hs_word_buffer`

## Requirements
- R1: While reset is high, and on the first cycle after it, src_ack, dst_req and dst_data are all zero and the slot is empty. A source request that arrives right after reset is answered on the next cycle.
- R2: When src_req is high, src_ack is low and the slot is empty at a clock edge, src_data is stored at that edge and src_ack is high from the following cycle on.
- R3: src_ack stays high for as long as src_req stays high, and it goes low one cycle after src_req is seen low.
- R4: While the slot holds a word that has not yet been delivered, src_req gets no acknowledge, however long it is held.
- R5: Once a word has been stored and dst_ack is low, dst_req rises one clock edge after the store.
- R6: dst_req stays high until dst_ack is seen high, and it falls one cycle after that. The slot is empty from the same edge.
- R7: dst_req does not rise while dst_ack from the previous delivery is still high. It rises one cycle after dst_ack falls if a word is waiting.
- R8: Between any two rising edges of src_ack there is exactly one completed delivery, and dst_req never rises without a stored, undelivered word. This rules out both overflow and underflow.
- R9: While dst_req is high, dst_data equals the word stored at the most recent rising edge of src_ack. The value on src_data after the store does not affect it.
- R10: With ZERO_IDLE set (the default), dst_data is zero whenever dst_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | 1 | Producer request: a word is on src_data |
| src_data | input | DATA_W (32) | Word from the producer |
| src_ack | output | 1 | Buffer acknowledge to the producer |
| dst_req | output | 1 | Buffer request: a word is on dst_data |
| dst_data | output | DATA_W (32) | Word offered to the consumer |
| dst_ack | input | 1 | Consumer acknowledge |

## Verification
A wrong fill state shows up within one or two cycles. If the slot is wrongly left empty, a waiting producer is acknowledged while dst_req is still open. If the slot is wrongly marked full, dst_req rises with nothing stored. If the fill state is lost, the next src_ack never comes. A broken capture or hold path shows at the ports the moment dst_req is high, because dst_data then differs from the word stored at the matching src_ack rise. Holding the consumer's acknowledge high across a new store exposes an offer side that looks only at the slot and ignores the previous acknowledge.

// File: rtl/hs_buf_pkg.sv
package hs_buf_pkg;

   // Source-side exchange: waiting for a request, or holding the acknowledge.
   typedef enum logic {
      SRC_WAIT = 1'b0,
      SRC_HELD = 1'b1
   } src_state_e;

   // Sink-side exchange: idle, or offering a word to the consumer.
   typedef enum logic {
      SNK_IDLE  = 1'b0,
      SNK_OFFER = 1'b1
   } snk_state_e;

endpackage

// File: rtl/hs_accept_port.sv
module hs_accept_port
   import hs_buf_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic req_i,
   input  logic slot_full_i,
   output logic ack_o,
   output logic load_o
);

   src_state_e state_q;
   src_state_e state_d;

   // A store happens only from the wait state, into an empty slot.
   assign load_o = (state_q == SRC_WAIT) && req_i && !slot_full_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SRC_WAIT: if (load_o) state_d = SRC_HELD;
         SRC_HELD: if (!req_i) state_d = SRC_WAIT;
         default:  state_d = SRC_WAIT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= SRC_WAIT;
      else     state_q <= state_d;
   end

   assign ack_o = (state_q == SRC_HELD);

endmodule

// File: rtl/hs_offer_port.sv
module hs_offer_port
   import hs_buf_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic slot_full_i,
   input  logic ack_i,
   output logic req_o,
   output logic take_o
);

   snk_state_e state_q;
   snk_state_e state_d;

   // The word counts as delivered when the consumer acknowledges an open offer.
   assign take_o = (state_q == SNK_OFFER) && ack_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         // A new offer waits for the previous acknowledge to return low.
         SNK_IDLE:  if (slot_full_i && !ack_i) state_d = SNK_OFFER;
         SNK_OFFER: if (ack_i) state_d = SNK_IDLE;
         default:   state_d = SNK_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= SNK_IDLE;
      else     state_q <= state_d;
   end

   assign req_o = (state_q == SNK_OFFER);

endmodule

// File: rtl/hs_word_slot.sv
module hs_word_slot #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_i,
   input  logic              take_i,
   input  logic              show_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              full_o,
   output logic [DATA_W-1:0] data_o
);

   localparam logic [DATA_W-1:0] DATA_ZERO = '0;

   logic [DATA_W-1:0] word_q;
   logic              full_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q <= DATA_ZERO;
         full_q <= 1'b0;
      end else begin
         if (load_i) begin
            word_q <= data_i;
            full_q <= 1'b1;
         end else if (take_i) begin
            full_q <= 1'b0;
         end
      end
   end

   assign full_o = full_q;

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         assign data_o = show_i ? word_q : DATA_ZERO;
      end else begin : g_always_show
         assign data_o = word_q;
      end
   endgenerate

endmodule

// File: rtl/hs_word_buffer.sv
module hs_word_buffer #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              src_req,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ack,
   output logic              dst_req,
   output logic [DATA_W-1:0] dst_data,
   input  logic              dst_ack
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hs_word_buffer: DATA_W must be at least 1");
      end
   endgenerate

   logic slot_full;
   logic load;
   logic take;

   hs_accept_port u_accept (
      .clk         (clk),
      .rst         (rst),
      .req_i       (src_req),
      .slot_full_i (slot_full),
      .ack_o       (src_ack),
      .load_o      (load)
   );

   hs_offer_port u_offer (
      .clk         (clk),
      .rst         (rst),
      .slot_full_i (slot_full),
      .ack_i       (dst_ack),
      .req_o       (dst_req),
      .take_o      (take)
   );

   hs_word_slot #(
      .DATA_W    (DATA_W),
      .ZERO_IDLE (ZERO_IDLE)
   ) u_slot (
      .clk    (clk),
      .rst    (rst),
      .load_i (load),
      .take_i (take),
      .show_i (dst_req),
      .data_i (src_data),
      .full_o (slot_full),
      .data_o (dst_data)
   );

endmodule

// File: rtl/hs_word_buffer_chk.sv
module hs_word_buffer_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter bit          ZERO_IDLE = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              src_req,
   input logic [DATA_W-1:0] src_data,
   input logic              src_ack,
   input logic              dst_req,
   input logic [DATA_W-1:0] dst_data,
   input logic              dst_ack
);

   logic              src_ack_d;
   logic              dst_req_d;
   logic              pending;
   logic [DATA_W-1:0] src_data_d;
   logic [DATA_W-1:0] shadow;

   always_ff @(posedge clk) begin
      if (rst) begin
         src_ack_d  <= 1'b0;
         dst_req_d  <= 1'b0;
         pending    <= 1'b0;
         src_data_d <= '0;
         shadow     <= '0;
      end else begin
         src_ack_d  <= src_ack;
         dst_req_d  <= dst_req;
         src_data_d <= src_data;
         if (src_ack && !src_ack_d) begin
            pending <= 1'b1;
            shadow  <= src_data_d;
         end else if (!dst_req && dst_req_d) begin
            pending <= 1'b0;
         end
      end
   end

   // R2
   src_ack_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
      (!src_ack && !src_req) |=> !src_ack);

   // R3
   src_ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (src_ack && src_req) |=> src_ack);

   // R3
   src_ack_release_chk: assert property (@(posedge clk) disable iff (rst)
      (src_ack && !src_req) |=> !src_ack);

   // R6
   dst_req_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (dst_req && !dst_ack) |=> dst_req);

   // R6
   dst_req_release_chk: assert property (@(posedge clk) disable iff (rst)
      (dst_req && dst_ack) |=> !dst_req);

   // R7
   no_offer_under_ack_chk: assert property (@(posedge clk) disable iff (rst)
      (!dst_req && dst_ack) |=> !dst_req);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      (src_ack && !src_ack_d) |-> !pending);

   // R8
   no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
      (dst_req && !dst_req_d) |-> pending);

   // R9
   data_match_chk: assert property (@(posedge clk) disable iff (rst)
      dst_req |-> (dst_data == shadow));

   generate
      if (ZERO_IDLE) begin : g_idle_chk
         // R10
         idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
            !dst_req |-> (dst_data == '0));
      end
   endgenerate

endmodule

bind hs_word_buffer hs_word_buffer_chk #(
   .DATA_W    (DATA_W),
   .ZERO_IDLE (ZERO_IDLE)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .src_req  (src_req),
   .src_data (src_data),
   .src_ack  (src_ack),
   .dst_req  (dst_req),
   .dst_data (dst_data),
   .dst_ack  (dst_ack)
);

// File: tb/hs_word_buffer_test.sv
module hs_word_buffer_test;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 32;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst;
   logic          src_req;
   logic [DW-1:0] src_data;
   logic          src_ack;
   logic          dst_req;
   logic [DW-1:0] dst_data;
   logic          dst_ack;

   int checks   = 0;
   int failures = 0;
   int cycles   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hs_word_buffer #(.DATA_W(DW), .ZERO_IDLE(1'b1)) uut (
      .clk      (clk),
      .rst      (rst),
      .src_req  (src_req),
      .src_data (src_data),
      .src_ack  (src_ack),
      .dst_req  (dst_req),
      .dst_data (dst_data),
      .dst_ack  (dst_ack)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WATCHDOG) begin
         failures = failures + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below %0d", cycles, WATCHDOG);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                      input logic [DW-1:0] exp);
      checks = checks + 1;
      if (!ok) begin
         failures = failures + 1;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic t_reset();
      rst = 1'b1; src_req = 1'b0; src_data = '0; dst_ack = 1'b0;
      step(); step();
      chk(src_ack == 1'b0, "R1 src_ack in reset", {31'd0, src_ack}, 0);
      chk(dst_req == 1'b0, "R1 dst_req in reset", {31'd0, dst_req}, 0);
      chk(dst_data == '0, "R1 dst_data in reset", dst_data, 0);
      rst = 1'b0;
      step();
      chk(src_ack == 1'b0 && dst_req == 1'b0, "R1 outputs after reset",
          {30'd0, src_ack, dst_req}, 0);
   endtask

   task automatic t_basic(input logic [DW-1:0] w);
      src_data = w; src_req = 1'b1;
      step();
      chk(src_ack == 1'b1, "R2 ack after store", {31'd0, src_ack}, 1);
      chk(dst_req == 1'b0, "R5 no offer in store cycle", {31'd0, dst_req}, 0);
      chk(dst_data == '0, "R10 zero while idle", dst_data, 0);
      src_req = 1'b0; src_data = 32'hFFFF_FFFF;
      step();
      chk(src_ack == 1'b0, "R3 ack drops after req", {31'd0, src_ack}, 0);
      chk(dst_req == 1'b1, "R5 offer one edge after store", {31'd0, dst_req}, 1);
      chk(dst_data == w, "R9 offered word", dst_data, w);
      step();
      chk(dst_req == 1'b1, "R6 offer held without ack", {31'd0, dst_req}, 1);
      dst_ack = 1'b1;
      step();
      chk(dst_req == 1'b0, "R6 offer withdrawn after ack", {31'd0, dst_req}, 0);
      chk(dst_data == '0, "R10 zero after delivery", dst_data, 0);
      dst_ack = 1'b0;
      step();
   endtask

   task automatic t_req_hold(input logic [DW-1:0] w);
      src_data = w; src_req = 1'b1;
      step();
      for (int i = 0; i < 4; i++) begin
         chk(src_ack == 1'b1, "R3 ack held with req", {31'd0, src_ack}, 1);
         step();
      end
      src_req = 1'b0;
      step();
      chk(src_ack == 1'b0, "R3 ack release", {31'd0, src_ack}, 0);
      chk(dst_req == 1'b1 && dst_data == w, "R9 word after long req", dst_data, w);
      dst_ack = 1'b1;
      step();
      dst_ack = 1'b0;
      step();
   endtask

   task automatic t_full_stall(input logic [DW-1:0] a, input logic [DW-1:0] b);
      src_data = a; src_req = 1'b1;
      step();
      src_req = 1'b0;
      step();
      chk(dst_req == 1'b1, "R5 offer of first word", {31'd0, dst_req}, 1);
      src_data = b; src_req = 1'b1;
      for (int i = 0; i < 5; i++) begin
         step();
         chk(src_ack == 1'b0, "R4 no ack while full", {31'd0, src_ack}, 0);
         chk(dst_data == a, "R9 held word unaffected by src_data", dst_data, a);
      end
      dst_ack = 1'b1;
      step();
      chk(dst_req == 1'b0 && src_ack == 1'b0, "R8 no store in delivery edge",
          {30'd0, src_ack, dst_req}, 0);
      dst_ack = 1'b0;
      step();
      chk(src_ack == 1'b1, "R8 waiting word stored after delivery", {31'd0, src_ack}, 1);
      src_req = 1'b0;
      step();
      chk(dst_req == 1'b1 && dst_data == b, "R9 second word", dst_data, b);
      dst_ack = 1'b1;
      step();
      dst_ack = 1'b0;
      step();
   endtask

   task automatic t_ack_held(input logic [DW-1:0] x, input logic [DW-1:0] y);
      src_data = x; src_req = 1'b1;
      step();
      src_req = 1'b0;
      step();
      dst_ack = 1'b1;
      step();
      chk(dst_req == 1'b0, "R6 delivered", {31'd0, dst_req}, 0);
      src_data = y; src_req = 1'b1;
      step();
      chk(src_ack == 1'b1, "R2 store while consumer ack high", {31'd0, src_ack}, 1);
      src_req = 1'b0;
      for (int i = 0; i < 4; i++) begin
         step();
         chk(dst_req == 1'b0, "R7 no offer under old ack", {31'd0, dst_req}, 0);
      end
      dst_ack = 1'b0;
      step();
      chk(dst_req == 1'b1, "R7 offer after ack falls", {31'd0, dst_req}, 1);
      chk(dst_data == y, "R9 word after held ack", dst_data, y);
      dst_ack = 1'b1;
      step();
      dst_ack = 1'b0;
      step();
   endtask

   task automatic t_mid_reset(input logic [DW-1:0] c, input logic [DW-1:0] d);
      src_data = c; src_req = 1'b1;
      step();
      src_req = 1'b0;
      step();
      rst = 1'b1;
      step();
      chk(dst_req == 1'b0 && src_ack == 1'b0, "R1 reset mid transfer",
          {30'd0, src_ack, dst_req}, 0);
      chk(dst_data == '0, "R1 data cleared", dst_data, 0);
      rst = 1'b0; src_data = d; src_req = 1'b1;
      step();
      chk(src_ack == 1'b1, "R1 slot empty after reset", {31'd0, src_ack}, 1);
      src_req = 1'b0;
      step();
      chk(dst_data == d, "R9 word after reset", dst_data, d);
      dst_ack = 1'b1;
      step();
      dst_ack = 1'b0;
      step();
   endtask

   task automatic t_stream(input int n);
      fork
         begin
            for (int i = 0; i < n; i++) begin
               src_data = (i * 32'h9E37_79B9) ^ 32'h0F0F_A5A5;
               src_req  = 1'b1;
               while (!src_ack) step();
               src_req  = 1'b0;
               src_data = 32'hDEAD_BEEF;
               while (src_ack) step();
            end
         end
         begin
            for (int i = 0; i < n; i++) begin
               while (!dst_req) step();
               for (int k = 0; k < (i % 3); k++) step();
               chk(dst_data == ((i * 32'h9E37_79B9) ^ 32'h0F0F_A5A5),
                   "R9 stream word order", dst_data,
                   (i * 32'h9E37_79B9) ^ 32'h0F0F_A5A5);
               dst_ack = 1'b1;
               while (dst_req) step();
               dst_ack = 1'b0;
            end
         end
      join
      step(); step();
   endtask

   initial begin
      t_reset();
      t_basic(32'hA5C3_0001);
      t_basic(32'h0000_0000);
      t_req_hold(32'h1234_5678);
      t_full_stall(32'hCAFE_0010, 32'h8001_0203);
      t_ack_held(32'h5555_AAAA, 32'h7FFF_FFFE);
      t_mid_reset(32'h0BAD_F00D, 32'hFEED_0042);
      t_stream(8);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule